// File: doc/BRIEF.md
# Cascadable Down-Counting Timer Pair

This block holds two down-counting timers, a narrow low timer and a wide high timer, behind a small read/write register interface. Each timer picks one of four clock-enable strobes as its tick, reloads from a programmable period value, and raises a sticky terminal-count flag and a one-cycle interrupt pulse on every expiry. The clocks themselves are generated elsewhere and arrive as single-cycle enable strobes on `src_tick`. By convention, strobe 0 is a 32.768 kHz tick, strobe 1 is 1.024 kHz, strobe 2 is 32 Hz and strobe 3 is the system clock.

Setting the chain bit in the low timer's control word links the two timers into one long timebase. The low timer then acts as a prescaler: it reloads itself on every expiry, and each expiry steps the high timer down by one. In this mode the high timer's live-count register reads back as the bitwise inverse of its counter, so software sees a rising value. Loading the low timer with (f_tick / 1 MHz) - 1 gives one high-timer step per microsecond.

Register map (`addr`): 0 low control, 1 low source select, 2 low period, 3 low live count, 4 high control, 5 high source select, 6 high period, 7 high live count. Control bits: bit0 run, bit1 reload request, bit2 chain (low timer only, reads 0 on the high timer), bit3 expiry flag (read only).

Top module: `cascade_timer_pair`

## Requirements
- R1: After reset, all eight registers read 0 and both interrupt outputs are low.
- R2: Writing a control word with bit1 set loads the counter from the period register on the following clock edge. Bit1 reads back as 1 for exactly one cycle after the write and then clears itself.
- R3: While running, a timer decrements by one on each cycle in which its selected strobe is high. Select value s (0..3) picks `src_tick[s]`. Strobes that are not selected have no effect.
- R4: A tick that finds a counter at 0 reloads the counter from the period register, sets the expiry flag and drives the timer's interrupt high for that one cycle. A period value of N therefore gives N+1 ticks between interrupts.
- R5: With control bit0 cleared, the counter holds its value whatever the strobes do.
- R6: Reading a control register returns the expiry flag in bit3 and clears the flag after the read. If a new expiry occurs in the same cycle, the flag stays set.
- R7: With the chain bit set, the high timer decrements once per low-timer expiry and ignores its own selected strobe.
- R8: The high live-count register returns the bitwise inverse of the counter while chained and the plain counter value otherwise. The low live-count register always returns its counter zero-extended.
- R9: Writing a period register does not change the running counter until the next reload.
- R10: The low period and counter are 24 bits wide, so a write of 0xFFFFFFFF reads back as 0x00FFFFFF. The high period register is 32 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 4 | Clock-enable strobes, one per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the flag on a control read) |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| lo_irq | output | 1 | Low timer expiry pulse |
| hi_irq | output | 1 | High timer expiry pulse |

## Verification
A corrupted counter shows on the live-count register in the same cycle, and the interrupt timing shows it no later than the next expiry. A counter that drifts by one tick shifts the interrupt spacing away from N+1. If the chain path is wrong, the inverted high count stops rising in steps of one per low period within the first low expiry. A reload request that does not clear itself keeps the counter pinned at the period value, and a run of ticks exposes this at once.

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair #(
  parameter int LO_W = 24,
  parameter int HI_W = 32,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    src_tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          lo_irq,
  output logic          hi_irq
);
  logic            lo_en, lo_rst, lo_comb, lo_flag;
  logic [1:0]      lo_sel;
  logic [LO_W-1:0] lo_load, lo_cnt;
  logic            hi_en, hi_rst, hi_flag;
  logic [1:0]      hi_sel;
  logic [HI_W-1:0] hi_load, hi_cnt;

  wire wr_lo_ctl = wr_en && addr == 3'd0;
  wire wr_lo_sel = wr_en && addr == 3'd1;
  wire wr_lo_ld  = wr_en && addr == 3'd2;
  wire wr_hi_ctl = wr_en && addr == 3'd4;
  wire wr_hi_sel = wr_en && addr == 3'd5;
  wire wr_hi_ld  = wr_en && addr == 3'd6;
  wire rd_lo_ctl = rd_en && addr == 3'd0;
  wire rd_hi_ctl = rd_en && addr == 3'd4;

  wire lo_adv = lo_en && !lo_rst && src_tick[lo_sel];
  wire lo_tc  = lo_adv && lo_cnt == '0;
  wire hi_adv = hi_en && !hi_rst && (lo_comb ? lo_tc : src_tick[hi_sel]);
  wire hi_tc  = hi_adv && hi_cnt == '0;

  wire [HI_W-1:0] hi_obs = lo_comb ? ~hi_cnt : hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_en <= 1'b0; lo_rst <= 1'b0; lo_comb <= 1'b0; lo_flag <= 1'b0;
      lo_sel <= '0; lo_load <= '0; lo_cnt <= '0; lo_irq <= 1'b0;
    end else begin
      if (wr_lo_ctl) begin
        lo_en   <= wdata[0];
        lo_rst  <= wdata[1];
        lo_comb <= wdata[2];
      end else begin
        lo_rst <= 1'b0;
      end
      if (wr_lo_sel) lo_sel  <= wdata[1:0];
      if (wr_lo_ld)  lo_load <= wdata[LO_W-1:0];
      if (lo_rst)      lo_cnt <= lo_load;
      else if (lo_adv) lo_cnt <= lo_tc ? lo_load : lo_cnt - 1'b1;
      if (lo_tc)          lo_flag <= 1'b1;
      else if (rd_lo_ctl) lo_flag <= 1'b0;
      lo_irq <= lo_tc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_en <= 1'b0; hi_rst <= 1'b0; hi_flag <= 1'b0;
      hi_sel <= '0; hi_load <= '0; hi_cnt <= '0; hi_irq <= 1'b0;
    end else begin
      if (wr_hi_ctl) begin
        hi_en  <= wdata[0];
        hi_rst <= wdata[1];
      end else begin
        hi_rst <= 1'b0;
      end
      if (wr_hi_sel) hi_sel  <= wdata[1:0];
      if (wr_hi_ld)  hi_load <= wdata[HI_W-1:0];
      if (hi_rst)      hi_cnt <= hi_load;
      else if (hi_adv) hi_cnt <= hi_tc ? hi_load : hi_cnt - 1'b1;
      if (hi_tc)          hi_flag <= 1'b1;
      else if (rd_hi_ctl) hi_flag <= 1'b0;
      hi_irq <= hi_tc;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0: rdata = DW'({lo_flag, lo_comb, lo_rst, lo_en});
      3'd1: rdata = DW'(lo_sel);
      3'd2: rdata = DW'(lo_load);
      3'd3: rdata = DW'(lo_cnt);
      3'd4: rdata = DW'({hi_flag, 1'b0, hi_rst, hi_en});
      3'd5: rdata = DW'(hi_sel);
      3'd6: rdata = DW'(hi_load);
      default: rdata = DW'(hi_obs);
    endcase
  end
endmodule

module cascade_timer_pair_chk #(
  parameter int LO_W = 24,
  parameter int HI_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [2:0]      addr,
  input logic            lo_en,
  input logic            lo_rst,
  input logic            lo_comb,
  input logic            lo_flag,
  input logic            lo_irq,
  input logic            hi_rst,
  input logic [LO_W-1:0] lo_cnt,
  input logic [HI_W-1:0] hi_cnt
);
  // R2
  restart_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_rst && !(wr_en && addr == 3'd0)) |=> !lo_rst);
  // R5
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_en && !lo_rst) |=> $stable(lo_cnt));
  // R4
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_irq |-> lo_flag);
  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd0) |=> (!lo_flag || lo_irq));
  // R7
  chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_comb && !hi_rst) |=> ($stable(hi_cnt) || lo_irq));
endmodule

bind cascade_timer_pair cascade_timer_pair_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .lo_en(lo_en), .lo_rst(lo_rst), .lo_comb(lo_comb), .lo_flag(lo_flag),
  .lo_irq(lo_irq), .hi_rst(hi_rst), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt)
);

// File: tb/tb_cascade_timer_pair.sv
module tb_cascade_timer_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        lo_irq, hi_irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cascade_timer_pair dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .lo_irq(lo_irq), .hi_irq(hi_irq)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    step();
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    step(); step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      peek(3'(a), v);
      check("R1", v, 32'h0);
    end
    check("R1", {30'b0, hi_irq, lo_irq}, 32'h0);

    // R10 widths
    wr(3'd2, 32'hFFFF_FFFF);
    peek(3'd2, v); check("R10", v, 32'h00FF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    peek(3'd6, v); check("R10", v, 32'hFFFF_FFFF);

    // R2 reload request and self-clear
    wr(3'd1, 32'd3);
    wr(3'd2, 32'd10);
    wr(3'd0, 32'h3);
    rd(3'd0, v); check("R2", v, 32'h3);
    peek(3'd3, v); check("R2", v, 32'd10);
    peek(3'd0, v); check("R2", v, 32'h1);

    // R3 each source select; others ignored
    for (int s = 0; s < 4; s++) begin
      wr(3'd1, 32'(s));
      wr(3'd0, 32'h3);
      step();
      src_tick = 4'(1 << s);
      repeat (s + 2) step();
      src_tick = '0;
      peek(3'd3, v); check("R3", v, 32'(10 - (s + 2)));
      src_tick = 4'(~(1 << s));
      repeat (3) step();
      src_tick = '0;
      peek(3'd3, v); check("R3", v, 32'(10 - (s + 2)));
    end

    // R4 / R6 / R8 period sweep on both timers, system-clock source
    for (int t = 0; t < 2; t++) begin
      for (int n = 0; n < 5; n++) begin
        int pulses, first;
        logic [2:0] base;
        base = t ? 3'd4 : 3'd0;
        pulses = 0; first = 0;
        wr(base + 3'd1, 32'd3);
        wr(base + 3'd2, 32'(n));
        wr(base, 32'h3);
        step();
        peek(base + 3'd3, v); check("R8", v, 32'(n));
        rd(base, v);
        src_tick = 4'b1000;
        for (int c = 1; c <= 2 * n + 2; c++) begin
          step();
          if (t ? hi_irq : lo_irq) begin
            pulses++;
            if (first == 0) first = c;
          end
        end
        src_tick = '0;
        check("R4", 32'(pulses), 32'd2);
        check("R4", 32'(first), 32'(n + 1));
        rd(base, v); check("R6", v, 32'h9);
        rd(base, v); check("R6", v, 32'h1);
      end
    end

    // R5 stop holds; R9 period write deferred
    wr(3'd2, 32'd100);
    wr(3'd0, 32'h3);
    step();
    src_tick = 4'b1000;
    repeat (5) step();
    src_tick = '0;
    wr(3'd0, 32'h0);
    src_tick = 4'b1111;
    repeat (5) step();
    src_tick = '0;
    peek(3'd3, v); check("R5", v, 32'd95);
    wr(3'd0, 32'h1);
    wr(3'd2, 32'd5);
    src_tick = 4'b1000;
    repeat (2) step();
    src_tick = '0;
    peek(3'd3, v); check("R9", v, 32'd93);

    // R7 / R8 chained mode
    wr(3'd5, 32'd0);
    wr(3'd6, 32'd1000);
    wr(3'd4, 32'h3);
    wr(3'd1, 32'd3);
    wr(3'd2, 32'd3);
    wr(3'd0, 32'h7);
    step();
    peek(3'd7, v); check("R8", v, ~32'd1000);
    src_tick = 4'b1001;
    for (int k = 1; k <= 5; k++) begin
      repeat (4) step();
      peek(3'd7, v); check("R7", v, ~(32'd1000 - 32'(k)));
    end
    src_tick = '0;
    wr(3'd0, 32'h1);
    peek(3'd7, v); check("R8", v, 32'd995);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule